// File: doc/BRIEF.md
# Descriptor Load Register Engine

This block sits on the slave side of a byte-wide command port. An external controller uses it to load a device descriptor image into a 500-byte on-chip RAM. The controller sends one address beat to select a register. Every data byte after that goes to the selected register, split into two nibble beats with the high nibble first. When the descriptor register is selected, the first two bytes give a 16-bit length, low byte first. The following bytes are then written into the RAM at increasing addresses until that many bytes have arrived.

A length of six selects a short form. The six bytes are then the vendor, product and device release identifiers, each low byte first. They override the fields of a built-in default descriptor, and no RAM writes take place. When a load completes, the block floats the bus pull-up for a fixed parse time and then reconnects it. It latches the full-speed-only request into the speed mode at that point. After a fixed attach time it pulses a completion strobe. That strobe sets an interrupt status bit, which the controller clears with an acknowledge.

A length above the RAM size, other than six, flags an error and the bytes that follow are dropped. Selecting any other register in the middle of a load aborts it.

Top module: `dl_desc_loader`

## Requirements
- R1: A beat with `cmd_is_addr`=1 selects register `cmd_data`. Each later data byte is built from two data beats to that register, using `cmd_data[3:0]` of the first beat as bits 7:4 and of the second as bits 3:0. Bits 7:4 of data beats are ignored. A new address beat discards a pending half byte. Data beats sent before any register has been selected are ignored.
- R2: After register 0x30 is selected, the first two bytes form the 16-bit length, low byte first.
- R3: For a length of 1 to 500, other than 6, the next bytes are written to RAM addresses 0, 1, 2 and onward. Each write is a one-cycle `ram_we` pulse in the cycle after the completing nibble beat. Exactly `length` writes occur, and data bytes after the last one are ignored.
- R4: `ram_addr` never reaches 500 while `ram_we` is high.
- R5: A length of 6 sets `short_form`=1. Its six bytes set `vid`, `pid` and `did`, each low byte first, and cause no RAM write. Any other length clears `short_form` once it is captured.
- R6: After the final byte of a load, `pullup_en` is 0 in the next cycle and stays 0 until exactly PARSE_CYCLES+1 cycles after that final beat. It then goes to 1. `enum_ok` pulses exactly ATTACH_CYCLES cycles after the pull-up reconnects.
- R7: Writing a byte to register 0x3A sets the full-speed request to bit 1 of that byte. `hs_disable` takes the value of this request when the pull-up reconnects and holds it until the next reconnection.
- R8: A length above 500 that is not 6 sets `len_err`=1. The bytes that follow cause no RAM write and no completion sequence. The next selection of 0x30 clears `len_err`.
- R9: `enum_ok` is high for a single cycle. It sets `irq_enumok`, which stays set until a cycle with `irq_ack`=1. If the set and the acknowledge fall in the same cycle, the set wins.
- R10: An address beat for a register other than 0x30 during a load aborts it: no further RAM writes and no completion. The next selection of 0x30 expects a new length and writes from address 0.
- R11: While reset is high, `pullup_en`, `ram_we`, `enum_ok`, `irq_enumok`, `len_err`, `short_form` and `hs_disable` are 0, and `vid`, `pid` and `did` are 0.
- R12: A length of 0 starts the completion sequence at once, with no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_is_addr | input | 1 | 1: beat is a register address; 0: beat is a data nibble |
| cmd_data | input | 8 | Address, or nibble in bits 3:0 |
| irq_ack | input | 1 | Clears the interrupt status bit |
| ram_we | output | 1 | Descriptor RAM write strobe |
| ram_addr | output | 9 | Descriptor RAM byte address |
| ram_wdata | output | 8 | Descriptor RAM write data |
| pullup_en | output | 1 | Bus pull-up connect control |
| hs_disable | output | 1 | Latched full-speed-only mode |
| short_form | output | 1 | Identifier override of the built-in descriptor in use |
| vid | output | 16 | Vendor identifier override |
| pid | output | 16 | Product identifier override |
| did | output | 16 | Device release override |
| len_err | output | 1 | Declared length too large |
| enum_ok | output | 1 | One-cycle completion strobe |
| irq_enumok | output | 1 | Completion interrupt status |

## Verification
The bench sends random descriptor loads with random nibble junk and checks every RAM byte. It also drives the boundary lengths 0, 6, 500 and 501. A design that miscounted the last byte would leave writes short or running past the declared length. A design that treated 6 like any other length would write RAM instead of setting the identifiers. The bench measures the float and attach times cycle by cycle from the final beat, which catches an off-by-one in either counter. It also checks mid-load aborts, a half byte discarded by a re-select, the speed request changing after reconnection, and an acknowledge held during the completion strobe. These catch a design that resumes a stale load, that lets the speed mode follow the register live, or that lets the acknowledge win over the set.

// File: rtl/dl_pkg.sv
package dl_pkg;
    localparam int LEN_W     = 16;
    localparam int SHORT_LEN = 6;

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_LEN_LO, SEQ_LEN_HI, SEQ_DATA, SEQ_SHORT, SEQ_DROP
    } seq_state_e;

    typedef enum logic [1:0] {
        AT_IDLE, AT_PARSE, AT_ATTACH
    } at_state_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] reg_addr;
        logic [7:0] data;
    } byte_beat_t;

    typedef struct packed {
        logic       vld;
        logic [7:0] addr;
    } addr_evt_t;

    function automatic logic is_short_len(input logic [LEN_W-1:0] l);
        return l == LEN_W'(SHORT_LEN);
    endfunction
endpackage

// File: rtl/dl_nibble_asm.sv
module dl_nibble_asm
    import dl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic       cmd_is_addr,
    input  logic [7:0] cmd_data,
    output byte_beat_t beat_o,
    output addr_evt_t  addr_o
);
    logic       sel_vld_q;
    logic [7:0] sel_q;
    logic       half_q;
    logic [3:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_vld_q <= 1'b0;
            sel_q     <= '0;
            half_q    <= 1'b0;
            hi_q      <= '0;
        end else if (cmd_valid) begin
            if (cmd_is_addr) begin
                sel_vld_q <= 1'b1;
                sel_q     <= cmd_data;
                half_q    <= 1'b0;
            end else if (sel_vld_q) begin
                if (!half_q) begin
                    hi_q   <= cmd_data[3:0];
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        addr_o.vld      = cmd_valid && cmd_is_addr;
        addr_o.addr     = cmd_data;
        beat_o.vld      = cmd_valid && !cmd_is_addr && sel_vld_q && half_q;
        beat_o.reg_addr = sel_q;
        beat_o.data     = {hi_q, cmd_data[3:0]};
    end

    // R1: a completed byte needs a register selected earlier
    assert_byte_needs_sel_R1: assert property (@(posedge clk) disable iff (rst)
        beat_o.vld |-> sel_vld_q);
endmodule

// File: rtl/dl_load_seq.sv
module dl_load_seq
    import dl_pkg::*;
#(
    parameter logic [7:0] DESC_REG = 8'h30,
    parameter int         DEPTH    = 500,
    localparam int        AW       = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  byte_beat_t      beat_i,
    input  addr_evt_t       addr_i,
    input  logic            busy,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic [7:0]      ram_wdata,
    output logic            short_form,
    output logic [15:0]     vid,
    output logic [15:0]     pid,
    output logic [15:0]     did,
    output logic            len_err,
    output logic            load_done
);
    seq_state_e       st_q;
    logic [LEN_W-1:0] len_q, cnt_q;
    logic [7:0]       len_lo_q;
    logic [7:0]       id_q [0:5];
    logic             desc_beat, last_byte;
    logic [LEN_W-1:0] new_len;

    assign desc_beat = beat_i.vld && (beat_i.reg_addr == DESC_REG);
    assign last_byte = (cnt_q == len_q - LEN_W'(1));
    assign new_len   = {beat_i.data, len_lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SEQ_IDLE;
            len_q      <= '0;
            cnt_q      <= '0;
            len_lo_q   <= '0;
            ram_we     <= 1'b0;
            ram_addr   <= '0;
            ram_wdata  <= '0;
            short_form <= 1'b0;
            len_err    <= 1'b0;
            load_done  <= 1'b0;
            for (int i = 0; i < 6; i++) id_q[i] <= '0;
        end else begin
            ram_we    <= 1'b0;
            load_done <= 1'b0;
            if (addr_i.vld) begin
                if (addr_i.addr == DESC_REG) begin
                    if (!busy) begin
                        st_q    <= SEQ_LEN_LO;
                        cnt_q   <= '0;
                        len_err <= 1'b0;
                    end
                end else begin
                    st_q <= SEQ_IDLE;
                end
            end else if (desc_beat) begin
                case (st_q)
                    SEQ_LEN_LO: begin
                        len_lo_q <= beat_i.data;
                        st_q     <= SEQ_LEN_HI;
                    end
                    SEQ_LEN_HI: begin
                        len_q <= new_len;
                        if (new_len == '0) begin
                            short_form <= 1'b0;
                            load_done  <= 1'b1;
                            st_q       <= SEQ_IDLE;
                        end else if (is_short_len(new_len)) begin
                            short_form <= 1'b1;
                            st_q       <= SEQ_SHORT;
                        end else if (new_len > LEN_W'(DEPTH)) begin
                            short_form <= 1'b0;
                            len_err    <= 1'b1;
                            st_q       <= SEQ_DROP;
                        end else begin
                            short_form <= 1'b0;
                            st_q       <= SEQ_DATA;
                        end
                    end
                    SEQ_DATA: begin
                        ram_we    <= 1'b1;
                        ram_addr  <= cnt_q[AW-1:0];
                        ram_wdata <= beat_i.data;
                        cnt_q     <= cnt_q + LEN_W'(1);
                        if (last_byte) begin
                            load_done <= 1'b1;
                            st_q      <= SEQ_IDLE;
                        end
                    end
                    SEQ_SHORT: begin
                        id_q[cnt_q[2:0]] <= beat_i.data;
                        cnt_q            <= cnt_q + LEN_W'(1);
                        if (cnt_q == LEN_W'(SHORT_LEN - 1)) begin
                            load_done <= 1'b1;
                            st_q      <= SEQ_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign vid = {id_q[1], id_q[0]};
    assign pid = {id_q[3], id_q[2]};
    assign did = {id_q[5], id_q[4]};

    assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (32'(ram_addr) < DEPTH));
    assert_short_no_ram_R5: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !short_form);
    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        len_err |-> (!ram_we && !load_done));
endmodule

// File: rtl/dl_attach_ctl.sv
module dl_attach_ctl
    import dl_pkg::*;
#(
    parameter int  PARSE_CYCLES  = 20,
    parameter int  ATTACH_CYCLES = 10,
    localparam int MAXC          = (PARSE_CYCLES > ATTACH_CYCLES) ? PARSE_CYCLES : ATTACH_CYCLES,
    localparam int CW            = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load_done,
    input  logic fs_req,
    input  logic irq_ack,
    output logic busy,
    output logic pullup_en,
    output logic hs_disable,
    output logic enum_ok,
    output logic irq_enumok
);
    at_state_e     st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= AT_IDLE;
            cnt_q      <= '0;
            pullup_en  <= 1'b0;
            hs_disable <= 1'b0;
            enum_ok    <= 1'b0;
            irq_enumok <= 1'b0;
        end else begin
            enum_ok <= 1'b0;
            case (st_q)
                AT_IDLE: if (load_done) begin
                    st_q      <= AT_PARSE;
                    cnt_q     <= '0;
                    pullup_en <= 1'b0;
                end
                AT_PARSE: if (cnt_q == CW'(PARSE_CYCLES - 1)) begin
                    st_q       <= AT_ATTACH;
                    cnt_q      <= '0;
                    pullup_en  <= 1'b1;
                    hs_disable <= fs_req;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
                default: if (cnt_q == CW'(ATTACH_CYCLES - 1)) begin
                    st_q    <= AT_IDLE;
                    enum_ok <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            endcase
            if (st_q == AT_ATTACH && cnt_q == CW'(ATTACH_CYCLES - 1))
                irq_enumok <= 1'b1;
            else if (irq_ack)
                irq_enumok <= 1'b0;
        end
    end

    assign busy = (st_q != AT_IDLE);

    assert_float_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        (load_done && !busy) |=> !pullup_en);
    assert_enum_attached_R6: assert property (@(posedge clk) disable iff (rst)
        enum_ok |-> pullup_en);
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pullup_en && $past(pullup_en)) |-> $stable(hs_disable));
    assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        enum_ok |=> !enum_ok);
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_enumok) |-> enum_ok);
endmodule

// File: rtl/dl_desc_loader.sv
module dl_desc_loader
    import dl_pkg::*;
#(
    parameter logic [7:0] DESC_REG      = 8'h30,
    parameter logic [7:0] CFG_REG       = 8'h3A,
    parameter int         FS_BIT        = 1,
    parameter int         DEPTH         = 500,
    parameter int         PARSE_CYCLES  = 20,
    parameter int         ATTACH_CYCLES = 10,
    localparam int        AW            = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_is_addr,
    input  logic [7:0]    cmd_data,
    input  logic          irq_ack,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    output logic          pullup_en,
    output logic          hs_disable,
    output logic          short_form,
    output logic [15:0]   vid,
    output logic [15:0]   pid,
    output logic [15:0]   did,
    output logic          len_err,
    output logic          enum_ok,
    output logic          irq_enumok
);
    byte_beat_t beat;
    addr_evt_t  addr_evt;
    logic       load_done, busy, fs_q;

    dl_nibble_asm u_nib (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_addr(cmd_is_addr),
        .cmd_data(cmd_data), .beat_o(beat), .addr_o(addr_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) fs_q <= 1'b0;
        else if (beat.vld && beat.reg_addr == CFG_REG) fs_q <= beat.data[FS_BIT];
    end

    dl_load_seq #(.DESC_REG(DESC_REG), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .beat_i(beat), .addr_i(addr_evt), .busy(busy),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .short_form(short_form), .vid(vid), .pid(pid), .did(did),
        .len_err(len_err), .load_done(load_done)
    );

    dl_attach_ctl #(.PARSE_CYCLES(PARSE_CYCLES), .ATTACH_CYCLES(ATTACH_CYCLES)) u_att (
        .clk(clk), .rst(rst), .load_done(load_done), .fs_req(fs_q), .irq_ack(irq_ack),
        .busy(busy), .pullup_en(pullup_en), .hs_disable(hs_disable),
        .enum_ok(enum_ok), .irq_enumok(irq_enumok)
    );
endmodule

// File: tb/dl_desc_loader_bench.sv
`timescale 1ns/1ps
module dl_desc_loader_bench;
    localparam int DEPTH = 500;
    localparam int PC    = 20;
    localparam int AC    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_is_addr = 1'b0, irq_ack = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        ram_we, pullup_en, hs_disable, short_form, len_err, enum_ok, irq_enumok;
    logic [8:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [15:0] vid, pid, did;

    int checks = 0, failures = 0, wr_cnt = 0, enum_seen = 0;
    logic [7:0] mem [0:511];
    logic [7:0] pay [0:511];
    bit finished = 0;

    always #2.5 clk = ~clk;

    dl_desc_loader u_dl_desc_loader (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_addr(cmd_is_addr),
        .cmd_data(cmd_data), .irq_ack(irq_ack), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .pullup_en(pullup_en), .hs_disable(hs_disable),
        .short_form(short_form), .vid(vid), .pid(pid), .did(did), .len_err(len_err),
        .enum_ok(enum_ok), .irq_enumok(irq_enumok)
    );

    always @(negedge clk) begin
        if (ram_we) begin
            mem[ram_addr] = ram_wdata;
            wr_cnt++;
        end
        if (enum_ok) enum_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_is_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        send(1'b0, {4'($urandom), b[7:4]});
        send(1'b0, {4'($urandom), b[3:0]});
    endtask

    task automatic start_len(input logic [15:0] l);
        send(1'b1, 8'h30);
        send_byte(l[7:0]);
        send_byte(l[15:8]);
    endtask

    function automatic logic [15:0] pair(input logic [7:0] lo, input logic [7:0] hi);
        return {hi, lo};
    endfunction

    // after the final beat returns: float, reconnect at PC+1, strobe AC later
    task automatic wait_enum(input logic exp_hs);
        int k = 1;
        int j = 0;
        @(negedge clk);
        chk(pullup_en == 1'b0, "R6 float", pullup_en, 0);
        while (!pullup_en && k < 2000) begin @(negedge clk); k++; end
        chk(k == PC + 1, "R6 reconnect delay", k, PC + 1);
        chk(hs_disable == exp_hs, "R7 latched mode", hs_disable, exp_hs);
        while (!enum_ok && j < 2000) begin @(negedge clk); j++; end
        chk(j == AC, "R6 strobe delay", j, AC);
        chk(irq_enumok == 1'b1, "R9 irq set", irq_enumok, 1);
        @(negedge clk);
        chk(enum_ok == 1'b0, "R9 one cycle", enum_ok, 0);
    endtask

    task automatic full_load(input int len, input logic exp_hs);
        for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
        wr_cnt = 0;
        start_len(16'(len));
        chk(short_form == 1'b0, "R5 cleared by full length", short_form, 0);
        for (int i = 0; i < len; i++) send_byte(pay[i]);
        wait_enum(exp_hs);
        chk(wr_cnt == len, "R3 write count", wr_cnt, len);
        for (int i = 0; i < len; i++)
            chk(mem[i] == pay[i], "R3 ram byte", mem[i], pay[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({pullup_en, ram_we, enum_ok, irq_enumok, len_err, short_form, hs_disable} == 7'b0,
            "R11 reset flags", {pullup_en, ram_we, enum_ok, irq_enumok}, 0);
        chk({vid, pid, did} == 48'b0, "R11 reset ids", vid, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: data before any select ignored
        send(1'b0, 8'h05); send(1'b0, 8'h06);
        repeat (2) @(negedge clk);
        chk(wr_cnt == 0 && !ram_we, "R1 unselected data", wr_cnt, 0);

        // R1/R2: half byte discarded by a re-select, then a normal load
        send(1'b1, 8'h30); send(1'b0, 8'h0F);
        wr_cnt = 0;
        for (int i = 0; i < 5; i++) pay[i] = 8'($urandom);
        start_len(16'd5);
        for (int i = 0; i < 5; i++) send_byte(pay[i]);
        wait_enum(1'b0);
        chk(wr_cnt == 5, "R1 re-select pairing count", wr_cnt, 5);
        chk(mem[4] == pay[4], "R2 length low first", mem[4], pay[4]);

        // R9 acknowledge clears
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk(irq_enumok == 1'b0, "R9 ack clears", irq_enumok, 0);

        // R3 random loads; also R3 trailing bytes ignored
        for (int t = 0; t < 6; t++) begin
            int l = 1 + int'($urandom % 40);
            if (l == 6) l = 7;
            full_load(l, 1'b0);
        end
        send_byte(8'hAA); send_byte(8'h55);
        repeat (2) @(negedge clk);
        chk(wr_cnt == 0 || !ram_we, "R3 trailing ignored", ram_we, 0);

        // R7 request then load; change after reconnect holds
        send(1'b1, 8'h3A); send_byte(8'h02);
        full_load(9, 1'b1);
        send(1'b1, 8'h3A); send_byte(8'h00);
        repeat (3) @(negedge clk);
        chk(hs_disable == 1'b1, "R7 holds after change", hs_disable, 1);
        full_load(3, 1'b0);

        // R4 boundary 500
        full_load(DEPTH, 1'b0);
        chk(mem[DEPTH-1] == pay[DEPTH-1], "R4 last address", mem[DEPTH-1], pay[DEPTH-1]);

        // R5 short form
        begin
            logic [7:0] b [0:5];
            for (int i = 0; i < 6; i++) b[i] = 8'($urandom);
            wr_cnt = 0;
            start_len(16'd6);
            for (int i = 0; i < 6; i++) send_byte(b[i]);
            chk(vid == pair(b[0], b[1]), "R5 vid", vid, pair(b[0], b[1]));
            chk(pid == pair(b[2], b[3]), "R5 pid", pid, pair(b[2], b[3]));
            chk(did == pair(b[4], b[5]), "R5 did", did, pair(b[4], b[5]));
            chk(short_form == 1'b1, "R5 flag", short_form, 1);
            wait_enum(1'b0);
            chk(wr_cnt == 0, "R5 no ram write", wr_cnt, 0);
        end

        // R8 length 501
        wr_cnt = 0; enum_seen = 0;
        start_len(16'd501);
        chk(len_err == 1'b1, "R8 err set", len_err, 1);
        for (int i = 0; i < 8; i++) send_byte(8'($urandom));
        repeat (PC + AC + 10) @(negedge clk);
        chk(wr_cnt == 0, "R8 dropped", wr_cnt, 0);
        chk(enum_seen == 0, "R8 no completion", enum_seen, 0);
        send(1'b1, 8'h30);
        chk(len_err == 1'b0, "R8 cleared by select", len_err, 0);

        // R10 abort mid-load, then restart from address 0
        wr_cnt = 0; enum_seen = 0;
        start_len(16'd10);
        for (int i = 0; i < 3; i++) send_byte(8'h11 * 8'(i + 1));
        send(1'b1, 8'h12);
        for (int i = 0; i < 9; i++) send_byte(8'($urandom));
        repeat (PC + AC + 10) @(negedge clk);
        chk(wr_cnt == 3, "R10 no writes after abort", wr_cnt, 3);
        chk(enum_seen == 0, "R10 no completion", enum_seen, 0);
        full_load(4, 1'b0);

        // R12 zero length, with ack held across the strobe (R9 set wins)
        wr_cnt = 0;
        irq_ack = 1'b1;
        start_len(16'd0);
        begin
            int k = 0;
            while (!enum_ok && k < 2000) begin @(negedge clk); k++; end
            chk(k == PC + AC + 1, "R12 completion delay", k, PC + AC + 1);
            chk(irq_enumok == 1'b1, "R9 set beats ack", irq_enumok, 1);
            @(negedge clk);
            chk(irq_enumok == 1'b0, "R9 ack after set", irq_enumok, 0);
        end
        irq_ack = 1'b0;
        chk(wr_cnt == 0, "R12 no ram write", wr_cnt, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule